// File: doc/BRIEF.md
# Receive Self-Test Stream Checker

This block sits behind the character decoders of a multi-channel serial receiver and checks, per channel, a self-test character stream against a sequence it generates locally. Each channel idles in a wait state until a start marker arrives. It then compares every following character against the expected stream, which is pseudo-random data from a linear feedback shift register with a command marker at fixed intervals. A 3-bit status code per channel reports each step of the run.

Each channel can be switched on or off through a shared set of enable inputs. These are captured under a latch-enable strobe, so that software-side wiring can update all channels at once. A run ends either after a fixed number of characters, with a flag on the final character if any mismatch occurred, or early, after a burst of consecutive mismatches. A per-channel saturating counter records how many characters failed to compare during the current run.

Top module: `bist_rx_checker`

## Requirements
- R1: While the reset input is low and afterwards until reconfigured, every status output reads 111, every error count reads 0, and every channel is disabled, with its captured enable bit at 1.
- R2: At a clock edge where `ben_le_i` is low, each captured enable bit takes the value of `ben_i`. While `ben_le_i` is high the captured bits hold. A captured 0 enables the channel. A captured 1 forces the channel to wait, where it reports 111 and ignores start markers.
- R3: An enabled waiting channel reports 111. A control character of value 0xBC is the start marker: it makes the channel report 101 and begin a run.
- R4: Run position p counts from 0 to 399. Where p mod 8 equals 7, the expected character is control character 0x7C. At every other position it is a data character equal to bits [7:0] of a 9-bit register. That register is seeded with 0x1FF at the start marker and steps as s <= {s[7:0], s[8]^s[4]} after each data position.
- R5: A character whose value and control flag both match the expectation, with its decode-error flag low, reports 000 at a data position and 001 at a command position.
- R6: A mismatch reports 110. A mismatch is a wrong value, a wrong control flag, or a raised decode-error flag.
- R7: The fourth mismatch in a row aborts the run. That character reports 111, and the channel returns to wait.
- R8: The character at position 399 ends the run, and the channel then returns to wait. That character reports 100 if any mismatch occurred during the run, counting itself; otherwise it reports its normal compare code.
- R9: The error count rises by one on each mismatch, saturates at 255, and clears to 0 on a start marker.
- R10: Channels are independent. Traffic on one channel does not change the status or count of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_i | input | NUM_CH*8 | Decoded character per channel, channel 0 in the low byte |
| ctrl_i | input | NUM_CH | Per-channel flag: character is a control character |
| derr_i | input | NUM_CH | Per-channel decode-error flag |
| ben_i | input | NUM_CH | Shared enable inputs, active low |
| ben_le_i | input | 1 | Latch enable; capture while low, hold while high |
| status_o | output | NUM_CH*3 | Per-channel status code |
| err_cnt_o | output | NUM_CH*8 | Per-channel saturating mismatch count |

## Verification
Every character result is registered once. Status and count therefore change at the clock edge that samples the character and appear one cycle after it is driven. A change to the enable inputs takes two edges to act: one to capture the bit, and one for the channel to use it. The bench drives inputs at the falling edge, lets a single rising edge pass, and reads the outputs at the next falling edge, so each status is compared against the character that produced it. For the enable path it waits the extra edge before checking. Its expected codes come from a running model of position, consecutive misses and the count, built from the requirements.

// File: rtl/bist_rx_pkg.sv
package bist_rx_pkg;
  localparam int CHAR_W = 8;
  localparam int LFSR_W = 9;

  typedef enum logic [2:0] {
    ST_DATA_OK  = 3'b000,
    ST_CMD_OK   = 3'b001,
    ST_LAST_BAD = 3'b100,
    ST_START    = 3'b101,
    ST_MISS     = 3'b110,
    ST_WAIT     = 3'b111
  } bist_stat_e;

  // x^9 + x^5 + 1, maximal length 511
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[8] ^ s[4]};
  endfunction
endpackage

// File: rtl/bist_rst_sync.sv
module bist_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/bist_en_capture.sv
module bist_en_capture #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ben_i,
  input  logic              le_i,
  output logic [NUM_CH-1:0] off_o
);
  logic [NUM_CH-1:0] off_q;
  logic [NUM_CH-1:0] off_d;
  logic              cap_en;

  assign cap_en = ~le_i;

  always_comb begin
    off_d = off_q;
    if (cap_en) off_d = ben_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '1;
    else        off_q <= off_d;
  end

  assign off_o = off_q;
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr
  import bist_rx_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] s_q;
  logic [LFSR_W-1:0] s_d;

  always_comb begin
    s_d = s_q;
    if (ld_i)        s_d = SEED;
    else if (step_i) s_d = lfsr_next(s_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= SEED;
    else        s_q <= s_d;
  end

  assign state_o = s_q;
endmodule

// File: rtl/bist_chan_chk.sv
module bist_chan_chk
  import bist_rx_pkg::*;
#(
  parameter int                RUN_LEN    = 400,
  parameter int                CMD_EVERY  = 8,
  parameter int                ABORT_N    = 4,
  parameter int                CNT_W      = 8,
  parameter logic [CHAR_W-1:0] START_CODE = 8'hBC,
  parameter logic [CHAR_W-1:0] CMD_CODE   = 8'h7C,
  parameter logic [LFSR_W-1:0] SEED       = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              ctrl_i,
  input  logic              derr_i,
  output logic              run_o,
  output logic [2:0]        stat_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int POS_W = $clog2(RUN_LEN);
  localparam int PH_W  = (CMD_EVERY > 1) ? $clog2(CMD_EVERY) : 1;
  localparam int CON_W = $clog2(ABORT_N + 1);
  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(RUN_LEN - 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(CMD_EVERY - 1);
  localparam logic [CON_W-1:0] ABORT_LIM = CON_W'(ABORT_N);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic               run_q,  run_d;
  logic [POS_W-1:0]   pos_q,  pos_d;
  logic [PH_W-1:0]    ph_q,   ph_d;
  logic [CON_W-1:0]   con_q,  con_d, con_inc;
  logic               bad_q,  bad_d;
  logic [CNT_W-1:0]   cnt_q,  cnt_d;
  bist_stat_e         stat_q, stat_d;
  logic               lf_ld, lf_step;
  logic [LFSR_W-1:0]  lf_state;
  logic               exp_cmd, hit;
  logic [CHAR_W-1:0]  exp_char;

  bist_lfsr #(.SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_i    (lf_ld),
    .step_i  (lf_step),
    .state_o (lf_state)
  );

  assign exp_cmd  = (ph_q == PH_LAST);
  assign exp_char = exp_cmd ? CMD_CODE : lf_state[CHAR_W-1:0];
  assign hit      = !derr_i && (ctrl_i == exp_cmd) && (char_i == exp_char);
  assign con_inc  = con_q + CON_W'(1);

  always_comb begin
    run_d   = run_q;
    pos_d   = pos_q;
    ph_d    = ph_q;
    con_d   = con_q;
    bad_d   = bad_q;
    cnt_d   = cnt_q;
    stat_d  = ST_WAIT;
    lf_ld   = 1'b0;
    lf_step = 1'b0;
    if (off_i) begin
      run_d = 1'b0;
    end else if (!run_q) begin
      if (ctrl_i && char_i == START_CODE) begin
        run_d  = 1'b1;
        pos_d  = '0;
        ph_d   = '0;
        con_d  = '0;
        bad_d  = 1'b0;
        cnt_d  = '0;
        lf_ld  = 1'b1;
        stat_d = ST_START;
      end
    end else begin
      pos_d   = pos_q + POS_W'(1);
      ph_d    = exp_cmd ? '0 : ph_q + PH_W'(1);
      lf_step = !exp_cmd;
      if (hit) begin
        con_d  = '0;
        stat_d = exp_cmd ? ST_CMD_OK : ST_DATA_OK;
      end else begin
        con_d  = con_inc;
        bad_d  = 1'b1;
        stat_d = ST_MISS;
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
      end
      if (!hit && con_inc == ABORT_LIM) begin
        run_d  = 1'b0;
        stat_d = ST_WAIT;
      end else if (pos_q == POS_LAST) begin
        run_d = 1'b0;
        if (!hit || bad_q) stat_d = ST_LAST_BAD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      ph_q   <= '0;
      con_q  <= '0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
      stat_q <= ST_WAIT;
    end else begin
      run_q  <= run_d;
      stat_q <= stat_d;
      if (run_d) begin
        pos_q <= pos_d;
        ph_q  <= ph_d;
        con_q <= con_d;
        bad_q <= bad_d;
      end
      if (cnt_d != cnt_q) cnt_q <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign stat_o = stat_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/bist_rx_checker.sv
module bist_rx_checker
  import bist_rx_pkg::*;
#(
  parameter int                NUM_CH     = 4,
  parameter int                RUN_LEN    = 400,
  parameter int                CMD_EVERY  = 8,
  parameter int                ABORT_N    = 4,
  parameter int                CNT_W      = 8,
  parameter logic [CHAR_W-1:0] START_CODE = 8'hBC,
  parameter logic [CHAR_W-1:0] CMD_CODE   = 8'h7C,
  parameter logic [LFSR_W-1:0] SEED       = 9'h1FF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH*CHAR_W-1:0] char_i,
  input  logic [NUM_CH-1:0]        ctrl_i,
  input  logic [NUM_CH-1:0]        derr_i,
  input  logic [NUM_CH-1:0]        ben_i,
  input  logic                     ben_le_i,
  output logic [NUM_CH*3-1:0]      status_o,
  output logic [NUM_CH*CNT_W-1:0]  err_cnt_o
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] off_q;
  logic [NUM_CH-1:0] run_v;

  bist_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_s)
  );

  bist_en_capture #(.NUM_CH(NUM_CH)) u_en (
    .clk   (clk),
    .rst_n (rst_n_s),
    .ben_i (ben_i),
    .le_i  (ben_le_i),
    .off_o (off_q)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    bist_chan_chk #(
      .RUN_LEN    (RUN_LEN),
      .CMD_EVERY  (CMD_EVERY),
      .ABORT_N    (ABORT_N),
      .CNT_W      (CNT_W),
      .START_CODE (START_CODE),
      .CMD_CODE   (CMD_CODE),
      .SEED       (SEED)
    ) u_chk (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .off_i  (off_q[g]),
      .char_i (char_i[g*CHAR_W +: CHAR_W]),
      .ctrl_i (ctrl_i[g]),
      .derr_i (derr_i[g]),
      .run_o  (run_v[g]),
      .stat_o (status_o[g*3 +: 3]),
      .cnt_o  (err_cnt_o[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: rtl/bist_rx_checker_sva.sv
module bist_rx_checker_sva #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH*3-1:0]     status,
  input logic [NUM_CH*CNT_W-1:0] cnt,
  input logic [NUM_CH-1:0]       run,
  input logic [NUM_CH-1:0]       off
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R3
    start_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i*3 +: 3] == 3'b101) |-> run[i]);
    // R8
    run_exit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run[i]) |-> (status[i*3 +: 3] inside {3'b111, 3'b100, 3'b000, 3'b001}));
    // R2
    off_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(off[i]) |-> (status[i*3 +: 3] == 3'b111 && !run[i]));
    // R6
    miss_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i*3 +: 3] == 3'b110) |-> (cnt[i*CNT_W +: CNT_W] != '0));
    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[i*CNT_W +: CNT_W] != $past(cnt[i*CNT_W +: CNT_W])) |->
      (cnt[i*CNT_W +: CNT_W] == '0 ||
       cnt[i*CNT_W +: CNT_W] == CNT_W'($past(cnt[i*CNT_W +: CNT_W]) + 1)));
  end
endmodule

bind bist_rx_checker bist_rx_checker_sva #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_sva (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .status (status_o),
  .cnt    (err_cnt_o),
  .run    (run_v),
  .off    (off_q)
);

// File: tb/bist_rx_checker_test.sv
`timescale 1ns/1ps
module bist_rx_checker_test;
  localparam int NUM_CH = 4;
  localparam int RUN_LEN = 400;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NUM_CH*8-1:0] char_i;
  logic [NUM_CH-1:0]   ctrl_i, derr_i, ben_i;
  logic                ben_le_i;
  logic [NUM_CH*3-1:0] status_o;
  logic [NUM_CH*8-1:0] err_cnt_o;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  bist_rx_checker uut (
    .clk(clk), .rst_n(rst_n), .char_i(char_i), .ctrl_i(ctrl_i), .derr_i(derr_i),
    .ben_i(ben_i), .ben_le_i(ben_le_i), .status_o(status_o), .err_cnt_o(err_cnt_o)
  );

  // {from[8:0], len[8:0], saw, exp_cnt[7:0], exp_abort}
  localparam logic [27:0] VEC [6] = '{
    {9'd0,   9'd0, 1'b0, 8'd0,   1'b0},
    {9'd5,   9'd1, 1'b0, 8'd1,   1'b0},
    {9'd10,  9'd3, 1'b0, 8'd3,   1'b0},
    {9'd2,   9'd4, 1'b0, 8'd4,   1'b1},
    {9'd399, 9'd1, 1'b0, 8'd1,   1'b0},
    {9'd0,   9'd0, 1'b1, 8'd255, 1'b0}
  };

  function automatic logic [8:0] nx(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_all();
    char_i = '0; ctrl_i = '0; derr_i = '0;
  endtask

  function automatic logic [2:0] st(input int ch);
    return status_o[ch*3 +: 3];
  endfunction

  function automatic logic [7:0] cn(input int ch);
    return err_cnt_o[ch*8 +: 8];
  endfunction

  task automatic play(input int ch, input int from, input int len, input bit saw,
                      input bit use_derr, output int fin_cnt, output bit aborted);
    logic [8:0] s = 9'h1FF;
    int con = 0, cnt = 0;
    bit anyb = 0, ab = 0;
    idle_all();
    char_i[ch*8 +: 8] = 8'hBC; ctrl_i[ch] = 1'b1;
    cyc();
    chk(st(ch) == 3'b101, "R3 start", st(ch), 5);
    chk(cn(ch) == 0, "R9 clear", cn(ch), 0);
    for (int p = 0; p < RUN_LEN; p++) begin
      bit cmd = (p % 8 == 7);
      bit bad = (p >= from && p < from + len) || (saw && p % 4 != 3);
      logic [7:0] ec = cmd ? 8'h7C : s[7:0];
      logic [2:0] ex;
      string tg;
      if (!cmd) s = nx(s);
      char_i[ch*8 +: 8] = ec ^ ((bad && !use_derr) ? 8'h01 : 8'h00);
      ctrl_i[ch] = cmd;
      derr_i[ch] = bad && use_derr;
      cyc();
      if (ab) begin ex = 3'b111; tg = "R7 after abort"; end
      else if (bad) begin
        con++; anyb = 1; if (cnt < 255) cnt++;
        if (con == 4) begin ex = 3'b111; ab = 1; tg = "R7 abort"; end
        else if (p == RUN_LEN-1) begin ex = 3'b100; tg = "R8 last bad"; end
        else begin ex = 3'b110; tg = "R6 miss"; end
      end else begin
        con = 0;
        if (p == RUN_LEN-1) begin ex = anyb ? 3'b100 : (cmd ? 3'b001 : 3'b000); tg = "R8 last"; end
        else begin ex = cmd ? 3'b001 : 3'b000; tg = "R5 match"; end
      end
      chk(st(ch) == ex, tg, st(ch), ex);
    end
    idle_all();
    cyc();
    chk(st(ch) == 3'b111, "R8 back to wait", st(ch), 7);
    chk(cn(ch) == cnt[7:0], "R9 count", cn(ch), cnt);
    for (int o = 0; o < NUM_CH; o++)
      if (o != ch) chk(st(o) == 3'b111, "R10 other channel", st(o), 7);
    fin_cnt = cnt;
    aborted = ab;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    int fc;
    bit ab;
    rst_n = 1'b0; ben_le_i = 1'b1; ben_i = '0; idle_all();
    repeat (3) cyc();
    for (int c = 0; c < NUM_CH; c++) begin
      chk(st(c) == 3'b111, "R1 reset status", st(c), 7);
      chk(cn(c) == 0, "R1 reset count", cn(c), 0);
    end
    rst_n = 1'b1;
    repeat (4) cyc();
    // R1/R2: disabled after reset, start ignored (latch held high)
    char_i[7:0] = 8'hBC; ctrl_i[0] = 1'b1;
    cyc(); cyc();
    chk(st(0) == 3'b111, "R2 disabled ignores start", st(0), 7);
    idle_all();
    // R2: capture while low
    ben_i = '0; ben_le_i = 1'b0;
    cyc();
    ben_le_i = 1'b1; ben_i = '1;   // held while high
    cyc();
    // table walk
    for (int v = 0; v < 6; v++) begin
      logic [27:0] e = VEC[v];
      play(0, int'(e[27:19]), int'(e[18:10]), e[9], 1'b0, fc, ab);
      chk(fc == int'(e[8:1]), "R9 table count", fc, e[8:1]);
      chk(ab == e[0], "R7 table abort", ab, e[0]);
    end
    // R9: new start clears saturated count
    char_i[7:0] = 8'hBC; ctrl_i[0] = 1'b1;
    cyc();
    chk(cn(0) == 0, "R9 clear after saturate", cn(0), 0);
    // abort run back to wait on channel 0
    idle_all(); char_i[7:0] = 8'h55;
    repeat (4) cyc();
    chk(st(0) == 3'b111, "R7 abort to wait", st(0), 7);
    idle_all();
    // R6: decode-error flag on channel 2
    play(2, 20, 2, 1'b0, 1'b1, fc, ab);
    chk(fc == 2, "R6 decode error count", fc, 2);
    // R4: clean run on channel 3
    play(3, 0, 0, 1'b0, 1'b0, fc, ab);
    chk(fc == 0, "R4 clean stream", fc, 0);
    // R2: disable channel 1 mid-run
    char_i[15:8] = 8'hBC; ctrl_i[1] = 1'b1;
    cyc();
    chk(st(1) == 3'b101, "R3 start ch1", st(1), 5);
    idle_all();
    ben_i = 4'b0010; ben_le_i = 1'b0;
    cyc();
    ben_le_i = 1'b1;
    cyc();
    chk(st(1) == 3'b111, "R2 disabled mid-run", st(1), 7);
    char_i[15:8] = 8'hBC; ctrl_i[1] = 1'b1;
    cyc(); cyc();
    chk(st(1) == 3'b111, "R2 disabled ignores start", st(1), 7);
    chk(st(0) == 3'b111, "R10 ch0 unaffected", st(0), 7);
    idle_all();
    summary();
  end
endmodule